// File: doc/BRIEF.md
# Almost-Full Flag Bus Group Selector

This block drives a narrow, shared status bus that exposes the almost-full condition of one group of eight queues out of thirty-two. The host picks a group by placing a group code on the shared write address bus while pulsing a flag-bus strobe with the address-enable input held low. The choice is registered on the write clock and stays in force until the next valid group selection.

Several devices can share one flag bus. The upper field of the address carries a device address, which is compared with the static device ID of this device. The device whose ID matches the last selection drives the bus. Every other device drops its bus-enable output and holds its flag lines at the inactive (high) level. The flag lines follow the live per-queue status of the selected group on every cycle. Each line is active low.

Top module: `afq_flag_mux`

## Requirements
- R1: While reset is asserted and after it, the selected group is 0 and the last selected device address is 0. `bus_en_o` is therefore high exactly when `dev_id_i` is 0.
- R2: A group selection happens on a rising clock edge where `strobe_i` is 1 and `addr_en_i` is 0. The new group and the new bus enable are visible on the outputs just after that edge.
- R3: On an edge where `strobe_i` is 0, or where `addr_en_i` is 1, the selected group and the bus enable do not change.
- R4: During a selection, address bits [4:2] have no effect.
- R5: Address bits [1:0] give the group code. Code g places queue `8*g+k` on flag line k, for k = 0..7. Codes 0, 1, 2 and 3 therefore cover queues 0-7, 8-15, 16-23 and 24-31.
- R6: Flag lines are active low. Line k is 0 exactly when status bit `8*g+k` of `af_status_i` is 1, meaning that queue is almost full.
- R7: The flag lines follow changes of `af_status_i` in the same cycle, with no register in between.
- R8: A selection edge whose address bits [7:5] differ from `dev_id_i` sets `bus_en_o` low and keeps the previously selected group. If `dev_id_i` later equals the stored device address, that retained group is driven again.
- R9: While `bus_en_o` is low, all flag lines are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_id_i | input | 3 | Static device ID |
| wr_addr_i | input | 8 | Shared write address bus: [7:5] device address, [4:2] unused, [1:0] group code |
| addr_en_i | input | 1 | Write address enable; must be 0 for a group selection |
| strobe_i | input | 1 | Flag-bus strobe; 1 requests a group selection |
| af_status_i | input | 32 | Per-queue almost-full status, 1 means almost full |
| flag_bus_no | output | 8 | Active-low almost-full flags of the selected group |
| bus_en_o | output | 1 | 1 when this device owns the flag bus |

## Verification
A group selection takes one register: its result is due on the outputs just after the selecting edge. A change of status or device ID reaches the outputs within the same cycle, with no register in between. The driver applies every stimulus on the falling edge. After the next rising edge it pushes the expected bus value, computed from its own group and device model. The monitor samples 2 ns after that rising edge, when both the registered selection and the combinational status path have settled.

// File: rtl/afq_pkg.sv
package afq_pkg;
  parameter int NUM_QUEUES = 32;
  parameter int GRP_W      = 8;
  parameter int DEV_ID_W   = 3;
  parameter int ADDR_W     = 8;

  localparam int NUM_GRP   = NUM_QUEUES / GRP_W;
  localparam int GRP_SEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int DEV_LSB   = ADDR_W - DEV_ID_W;

  typedef logic [GRP_SEL_W-1:0] grp_sel_t;
  typedef logic [DEV_ID_W-1:0]  dev_id_t;
  typedef logic [GRP_W-1:0]     flag_vec_t;
endpackage

// File: rtl/afq_sel_dec.sv
module afq_sel_dec
  import afq_pkg::*;
(
  input  logic              strobe_i,
  input  logic              addr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  dev_id_t           dev_id_i,
  output logic              sel_vld_o,
  output logic              id_hit_o,
  output dev_id_t           addr_dev_o,
  output grp_sel_t          addr_grp_o
);
  // middle address bits are don't-care during a group selection
  assign addr_dev_o = wr_addr_i[ADDR_W-1:DEV_LSB];
  assign addr_grp_o = wr_addr_i[GRP_SEL_W-1:0];
  assign sel_vld_o  = strobe_i & ~addr_en_i;
  assign id_hit_o   = (addr_dev_o == dev_id_i);
endmodule

// File: rtl/afq_sel_reg.sv
module afq_sel_reg
  import afq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_vld_i,
  input  logic     id_hit_i,
  input  dev_id_t  addr_dev_i,
  input  grp_sel_t addr_grp_i,
  output grp_sel_t grp_q_o,
  output dev_id_t  dev_q_o
);
  grp_sel_t grp_q;
  dev_id_t  dev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      dev_q <= '0;
    end else if (sel_vld_i) begin
      dev_q <= addr_dev_i;
      // a selection addressed to another device keeps the local group
      if (id_hit_i) grp_q <= addr_grp_i;
    end
  end

  assign grp_q_o = grp_q;
  assign dev_q_o = dev_q;
endmodule

// File: rtl/afq_grp_mux.sv
module afq_grp_mux
  import afq_pkg::*;
(
  input  logic [NUM_QUEUES-1:0] af_status_i,
  input  grp_sel_t              grp_sel_i,
  input  logic                  drive_en_i,
  output flag_vec_t             flag_bus_no
);
  flag_vec_t masked [NUM_GRP];
  flag_vec_t picked;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit       = (grp_sel_i == grp_sel_t'(g));
    assign masked[g] = af_status_i[g*GRP_W +: GRP_W] & {GRP_W{hit}};
  end

  always_comb begin
    picked = '0;
    for (int g = 0; g < NUM_GRP; g++) picked |= masked[g];
  end

  assign flag_bus_no = drive_en_i ? ~picked : '1;
endmodule

// File: rtl/afq_flag_mux.sv
module afq_flag_mux
  import afq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DEV_ID_W-1:0]   dev_id_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic                  addr_en_i,
  input  logic                  strobe_i,
  input  logic [NUM_QUEUES-1:0] af_status_i,
  output logic [GRP_W-1:0]      flag_bus_no,
  output logic                  bus_en_o
);
  logic     sel_vld, id_hit;
  dev_id_t  addr_dev, dev_q;
  grp_sel_t addr_grp, grp_q;

  afq_sel_dec i_dec (
    .strobe_i   (strobe_i),
    .addr_en_i  (addr_en_i),
    .wr_addr_i  (wr_addr_i),
    .dev_id_i   (dev_id_i),
    .sel_vld_o  (sel_vld),
    .id_hit_o   (id_hit),
    .addr_dev_o (addr_dev),
    .addr_grp_o (addr_grp)
  );

  afq_sel_reg i_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_vld_i  (sel_vld),
    .id_hit_i   (id_hit),
    .addr_dev_i (addr_dev),
    .addr_grp_i (addr_grp),
    .grp_q_o    (grp_q),
    .dev_q_o    (dev_q)
  );

  assign bus_en_o = (dev_q == dev_id_i);

  afq_grp_mux i_mux (
    .af_status_i (af_status_i),
    .grp_sel_i   (grp_q),
    .drive_en_i  (bus_en_o),
    .flag_bus_no (flag_bus_no)
  );
endmodule

// File: rtl/afq_flag_mux_chk.sv
module afq_flag_mux_chk
  import afq_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [DEV_ID_W-1:0]   dev_id_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic                  addr_en_i,
  input logic                  strobe_i,
  input logic [NUM_QUEUES-1:0] af_status_i,
  input logic [GRP_W-1:0]      flag_bus_no,
  input logic                  bus_en_o,
  input grp_sel_t              grp_q
);
  // R9
  released_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_o |-> (flag_bus_no == '1));

  // R3
  no_sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && !addr_en_i) |=> $stable(grp_q));

  // R8
  foreign_sel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !addr_en_i && wr_addr_i[ADDR_W-1:DEV_LSB] != dev_id_i)
    |=> ($stable(grp_q) && (!bus_en_o || !$stable(dev_id_i))));

  // R2
  own_sel_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !addr_en_i && wr_addr_i[ADDR_W-1:DEV_LSB] == dev_id_i)
    |=> (grp_q == $past(wr_addr_i[GRP_SEL_W-1:0]) && (bus_en_o || !$stable(dev_id_i))));

  // R6
  flag_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> (flag_bus_no == ~af_status_i[grp_q*GRP_W +: GRP_W]));
endmodule

bind afq_flag_mux afq_flag_mux_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_id_i    (dev_id_i),
  .wr_addr_i   (wr_addr_i),
  .addr_en_i   (addr_en_i),
  .strobe_i    (strobe_i),
  .af_status_i (af_status_i),
  .flag_bus_no (flag_bus_no),
  .bus_en_o    (bus_en_o),
  .grp_q       (grp_q)
);

// File: tb/test_afq_flag_mux.sv
module test_afq_flag_mux;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  dev_id_i = 3'd0;
  logic [7:0]  wr_addr_i = '0;
  logic        addr_en_i = 1'b1;
  logic        strobe_i = 1'b0;
  logic [31:0] af_status_i = '0;
  logic [7:0]  flag_bus_no;
  logic        bus_en_o;

  typedef struct {
    logic       en;
    logic [7:0] flags;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic [1:0] m_grp = 2'd0;
  logic [2:0] m_dev = 3'd0;
  bit   done = 1'b0;

  always #4 clk_i = ~clk_i;

  afq_flag_mux i_afq_flag_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_id_i    (dev_id_i),
    .wr_addr_i   (wr_addr_i),
    .addr_en_i   (addr_en_i),
    .strobe_i    (strobe_i),
    .af_status_i (af_status_i),
    .flag_bus_no (flag_bus_no),
    .bus_en_o    (bus_en_o)
  );

  function automatic exp_t model(string tag);
    exp_t e;
    e.en    = (m_dev == dev_id_i);
    e.flags = e.en ? ~af_status_i[m_grp*8 +: 8] : 8'hFF;
    e.tag   = tag;
    return e;
  endfunction

  // one cycle of stimulus; expectation pushed after the rising edge
  task automatic step(input logic stb, input logic aen, input logic [7:0] addr,
                      input logic [31:0] st, input logic [2:0] dev, input string tag);
    @(negedge clk_i);
    strobe_i = stb; addr_en_i = aen; wr_addr_i = addr;
    af_status_i = st; dev_id_i = dev;
    @(posedge clk_i);
    if (rst_ni && stb && !aen) begin
      m_dev = addr[7:5];
      if (addr[7:5] == dev) m_grp = addr[1:0];
    end
    #1;
    exp_q.push_back(model(tag));
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (bus_en_o !== e.en || flag_bus_no !== e.flags) begin
          errors++;
          $display("FAIL %s: en=%b flags=%h expected en=%b flags=%h",
                   e.tag, bus_en_o, flag_bus_no, e.en, e.flags);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] st;
    st = 32'h5A3C_C381;
    // R1 reset state
    step(1'b0, 1'b1, 8'h00, st, 3'd0, "R1");
    step(1'b1, 1'b0, 8'hE3, st, 3'd3, "R1");
    @(negedge clk_i); rst_ni = 1'b1;
    // R9 foreign device idle after reset
    step(1'b0, 1'b1, 8'h00, st, 3'd2, "R9");
    // R2 select own device, group 1
    step(1'b1, 1'b0, {3'd2, 3'b000, 2'd1}, st, 3'd2, "R2");
    // R4 middle bits set, group 2
    step(1'b1, 1'b0, {3'd2, 3'b111, 2'd2}, st, 3'd2, "R4");
    // R5 groups 3 and 0
    step(1'b1, 1'b0, {3'd2, 3'b010, 2'd3}, st, 3'd2, "R5");
    step(1'b1, 1'b0, {3'd2, 3'b000, 2'd0}, st, 3'd2, "R5");
    step(1'b1, 1'b0, {3'd2, 3'b000, 2'd3}, st, 3'd2, "R5");
    // R3 no strobe, or address enable high
    step(1'b0, 1'b0, {3'd2, 3'b000, 2'd1}, st, 3'd2, "R3");
    step(1'b1, 1'b1, {3'd2, 3'b000, 2'd2}, st, 3'd2, "R3");
    // R6 / R7 live status patterns
    step(1'b0, 1'b1, 8'h00, 32'hFF00_0000, 3'd2, "R6");
    step(1'b0, 1'b1, 8'h00, 32'h00FF_FFFF, 3'd2, "R6");
    step(1'b0, 1'b1, 8'h00, 32'h8100_0000, 3'd2, "R7");
    step(1'b0, 1'b1, 8'h00, 32'h1800_0000, 3'd2, "R7");
    // R8 foreign selection releases bus, group kept
    step(1'b1, 1'b0, {3'd5, 3'b000, 2'd1}, st, 3'd2, "R8");
    step(1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, 3'd2, "R9");
    step(1'b0, 1'b1, 8'h00, st, 3'd5, "R8");
    // R2 reclaim with a new group
    step(1'b1, 1'b0, {3'd2, 3'b000, 2'd2}, st, 3'd2, "R2");
    step(1'b1, 1'b0, {3'd2, 3'b000, 2'd1}, 32'h0000_A500, 3'd2, "R5");
    @(posedge clk_i); @(posedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule